// File: doc/BRIEF.md
# Standard-Selectable Vertical Line Decimator

This block sits between a progressive camera stream of 1024 samples by 768 lines and a frame store. For every incoming sample it decides whether the sample is written and, if so, at which address. The result is a frame store that holds either a 525-line-standard picture (480 lines of 720 samples) or a 625-line-standard picture (512 lines of 680 samples). Each output line is a centred slice of an input line.

A single standard-select pin chooses the drop pattern and the horizontal window. The block takes that pin only when a frame begins, so the choice holds for the whole frame. A frame-start marker and a line-start marker each travel with the first sample of their frame or line. A valid strobe qualifies each sample. When a frame ends, the block counts the lines it kept. If the count does not equal the target for that frame's standard, it raises an error pulse.

Top module: `vline_decimator`

## Requirements
- R1: After reset, wr_en_o and frame_err_o are 0. No sample is written until the first frame-start marker has been seen.
- R2: A cycle with vs_i=1 carries sample 0 of line 0 of a new frame. A cycle with hs_i=1 and vs_i=0 carries sample 0 of the next line. When both are 1, the frame start wins and the line index becomes 0.
- R3: With std_sel_i=0 (525-line standard), a line whose index modulo 8 is 2, 5 or 7 is never written, and every other line below 768 is written inside the window.
- R4: With std_sel_i=1 (625-line standard), a line whose index modulo 3 is 2 is never written, and every other line below 768 is written inside the window.
- R5: The standard is taken from std_sel_i only in a cycle with vs_i=1. A change of the pin in mid-frame does not alter that frame's pattern or window.
- R6: In the 525-line standard, only samples with index 152 to 871 inclusive (720 samples) of a kept line are written.
- R7: In the 625-line standard, only samples with index 172 to 851 inclusive (680 samples) of a kept line are written.
- R8: Lines with index 768 or above, and samples with index 1024 or above, are never written.
- R9: wr_en_o and wr_addr_o show a sample one cycle after it is presented. The first write of a frame has address 0, and each later write in the same frame has the previous address plus 1.
- R10: In the cycle after a frame-start marker that follows an earlier frame start, frame_err_o is 1 exactly when the closing frame kept a line count other than 480 (525-line standard) or 512 (625-line standard). frame_err_o is 0 in all other cycles.
- R11: A cycle with vld_i=0 writes nothing and does not advance the sample index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vs_i | input | 1 | Frame-start marker, on the first sample of a frame |
| hs_i | input | 1 | Line-start marker, on the first sample of a line |
| vld_i | input | 1 | Sample valid strobe |
| std_sel_i | input | 1 | Standard select: 0 = 525-line, 1 = 625-line |
| wr_en_o | output | 1 | Frame-store write enable |
| wr_addr_o | output | 19 | Frame-store write address |
| frame_err_o | output | 1 | One-cycle pulse: the closing frame kept the wrong line count |

## Verification
A frame-start marker can arrive in the same cycle as a line-start marker and a valid sample. In that one cycle the block must do two things. It judges the closing frame's kept-line count against that frame's own standard. It also restarts the line, sample and address counting for the new frame. The bench provokes this by closing a deliberately short 700-line frame with vs_i, hs_i and vld_i all high together. It expects the error pulse one cycle later, then expects line 0 of the new frame under the newly captured standard, with the first kept write at address 0.

// File: rtl/vldec_pkg.sv
package vldec_pkg;

   typedef enum logic {
      STD_525 = 1'b0,
      STD_625 = 1'b1
   } std_e;

   function automatic int ones8(input logic [7:0] m);
      int n;
      n = 0;
      for (int i = 0; i < 8; i++) n += int'(m[i]);
      return n;
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/vldec_line_trk.sv
module vldec_line_trk
   import vldec_pkg::*;
#(
   parameter int          LINES = 768,
   parameter logic [7:0]  DROP  = 8'b1010_0100,
   localparam int         LW    = $clog2(LINES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic vs_i,
   input  logic hs_i,
   input  std_e std_i,
   output std_e cur_mode_o,
   output std_e frame_mode_o,
   output logic armed_o,
   output logic prior_o,
   output logic line_go_o,
   output logic keep_o
);

   logic [LW-1:0] line_q, line_d;
   logic [1:0]    ph_q, ph_d;
   std_e          mode_q, mode_d;
   logic          armed_q;
   logic [7:0]    lut525;

   initial begin
      assert (LW >= 3) else $error("line counter too narrow for the 8-line group");
   end

   for (genvar p = 0; p < 8; p++) begin : g_lut
      assign lut525[p] = !DROP[p];
   end

   always_comb begin
      line_d = line_q;
      ph_d   = ph_q;
      mode_d = mode_q;
      if (vs_i) begin
         line_d = '0;
         ph_d   = 2'd0;
         mode_d = std_i;
      end else if (hs_i) begin
         line_d = (line_q == LW'(LINES)) ? line_q : line_q + 1'b1;
         ph_d   = (ph_q == 2'd2) ? 2'd0 : ph_q + 2'd1;
      end
   end

   assign keep_o = (line_d < LW'(LINES)) &&
                   ((mode_d == STD_525) ? lut525[line_d[2:0]] : (ph_d != 2'd2));

   assign line_go_o    = vs_i | hs_i;
   assign armed_o      = armed_q | vs_i;
   assign prior_o      = armed_q;
   assign cur_mode_o   = mode_d;
   assign frame_mode_o = mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_q  <= '0;
         ph_q    <= 2'd0;
         mode_q  <= STD_525;
         armed_q <= 1'b0;
      end else begin
         line_q  <= line_d;
         ph_q    <= ph_d;
         mode_q  <= mode_d;
         armed_q <= armed_q | vs_i;
      end
   end

   // R4: the modulo-3 phase register stays in step with the line index
   a_r4_phase_agrees: assert property (@(posedge clk) disable iff (!rst_n)
      (line_q < LW'(LINES)) |-> (ph_q == 2'(line_q % 3)));

endmodule

// File: rtl/vldec_smp_win.sv
module vldec_smp_win
   import vldec_pkg::*;
#(
   parameter int  SMP  = 1024,
   parameter int  W525 = 720,
   parameter int  W625 = 680,
   localparam int SW   = $clog2(SMP + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_go_i,
   input  logic vld_i,
   input  std_e mode_i,
   output logic in_win_o
);

   localparam int LO525 = (SMP - W525) / 2;
   localparam int HI525 = LO525 + W525 - 1;
   localparam int LO625 = (SMP - W625) / 2;
   localparam int HI625 = LO625 + W625 - 1;

   logic [SW-1:0] smp_q, cur_smp;
   logic          win525, win625;

   initial begin
      assert (W525 <= SMP && W625 <= SMP && W525 > 0 && W625 > 0)
         else $error("window wider than the line");
   end

   assign cur_smp = line_go_i ? '0 : smp_q;

   if (LO525 == 0) begin : g_525_full
      assign win525 = cur_smp <= SW'(HI525);
   end else begin : g_525_mid
      assign win525 = (cur_smp >= SW'(LO525)) && (cur_smp <= SW'(HI525));
   end

   if (LO625 == 0) begin : g_625_full
      assign win625 = cur_smp <= SW'(HI625);
   end else begin : g_625_mid
      assign win625 = (cur_smp >= SW'(LO625)) && (cur_smp <= SW'(HI625));
   end

   assign in_win_o = vld_i && ((mode_i == STD_625) ? win625 : win525);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         smp_q <= '0;
      end else if (vld_i) begin
         smp_q <= (cur_smp == SW'(SMP)) ? cur_smp : cur_smp + 1'b1;
      end else begin
         smp_q <= cur_smp;
      end
   end

   // R8: the sample index saturates at the line length
   a_r8_index_capped: assert property (@(posedge clk) disable iff (!rst_n)
      smp_q <= SW'(SMP));

endmodule

// File: rtl/vldec_frame_acct.sv
module vldec_frame_acct
   import vldec_pkg::*;
#(
   parameter int AW      = 19,
   parameter int LW      = 10,
   parameter int KEEP525 = 480,
   parameter int KEEP625 = 512
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          vs_i,
   input  logic          line_go_i,
   input  logic          keep_i,
   input  logic          we_i,
   input  logic          prior_i,
   input  std_e          frame_mode_i,
   output logic          wr_en_o,
   output logic [AW-1:0] wr_addr_o,
   output logic          frame_err_o
);

   logic [AW-1:0] addr_q, cur_addr;
   logic [LW-1:0] kept_q, kept_base, target;

   assign cur_addr  = vs_i ? '0 : addr_q;
   assign kept_base = vs_i ? '0 : kept_q;
   assign target    = (frame_mode_i == STD_625) ? LW'(KEEP625) : LW'(KEEP525);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q      <= '0;
         kept_q      <= '0;
         wr_en_o     <= 1'b0;
         wr_addr_o   <= '0;
         frame_err_o <= 1'b0;
      end else begin
         addr_q      <= cur_addr + AW'(we_i);
         kept_q      <= kept_base + LW'(line_go_i && keep_i);
         wr_en_o     <= we_i;
         wr_addr_o   <= cur_addr;
         frame_err_o <= vs_i && prior_i && (kept_q != target);
      end
   end

   // checker state: last written address and "no write yet in this frame"
   logic [AW-1:0] prev_wa_q;
   logic          fresh_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_wa_q <= '0;
         fresh_q   <= 1'b0;
      end else begin
         if (wr_en_o) prev_wa_q <= wr_addr_o;
         fresh_q <= vs_i ? 1'b1 : (wr_en_o ? 1'b0 : fresh_q);
      end
   end

   // R9: first write after a frame start lands at address 0
   a_r9_first_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_o && fresh_q) |-> (wr_addr_o == '0));

   // R9: later writes step by exactly one
   a_r9_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_o && !fresh_q) |-> (wr_addr_o == prev_wa_q + 1'b1));

   // R10: an error pulse only follows a frame-start marker
   a_r10_err_after_vs: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err_o |-> $past(vs_i));

endmodule

// File: rtl/vline_decimator.sv
module vline_decimator
   import vldec_pkg::*;
#(
   parameter int          SMP_PER_LINE    = 1024,
   parameter int          LINES_PER_FRAME = 768,
   parameter int          WIN_525         = 720,
   parameter int          WIN_625         = 680,
   parameter logic [7:0]  DROP_525        = 8'b1010_0100,
   localparam int         KEEP_525        = LINES_PER_FRAME / 8 * (8 - ones8(DROP_525)),
   localparam int         KEEP_625        = LINES_PER_FRAME / 3 * 2,
   localparam int         MAX_WR          = max2(KEEP_525 * WIN_525, KEEP_625 * WIN_625),
   localparam int         AW              = $clog2(MAX_WR),
   localparam int         LW              = $clog2(LINES_PER_FRAME + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          vs_i,
   input  logic          hs_i,
   input  logic          vld_i,
   input  logic          std_sel_i,
   output logic          wr_en_o,
   output logic [AW-1:0] wr_addr_o,
   output logic          frame_err_o
);

   initial begin
      assert (LINES_PER_FRAME % 24 == 0)
         else $error("frame height must split into whole 8- and 3-line groups");
   end

   std_e cur_mode, frame_mode;
   logic armed, prior, line_go, keep_line, in_win, we;

   vldec_line_trk #(
      .LINES (LINES_PER_FRAME),
      .DROP  (DROP_525)
   ) u_line (
      .clk          (clk),
      .rst_n        (rst_n),
      .vs_i         (vs_i),
      .hs_i         (hs_i),
      .std_i        (std_e'(std_sel_i)),
      .cur_mode_o   (cur_mode),
      .frame_mode_o (frame_mode),
      .armed_o      (armed),
      .prior_o      (prior),
      .line_go_o    (line_go),
      .keep_o       (keep_line)
   );

   vldec_smp_win #(
      .SMP  (SMP_PER_LINE),
      .W525 (WIN_525),
      .W625 (WIN_625)
   ) u_win (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_go_i (line_go),
      .vld_i     (vld_i),
      .mode_i    (cur_mode),
      .in_win_o  (in_win)
   );

   assign we = armed && keep_line && in_win;

   vldec_frame_acct #(
      .AW      (AW),
      .LW      (LW),
      .KEEP525 (KEEP_525),
      .KEEP625 (KEEP_625)
   ) u_acct (
      .clk          (clk),
      .rst_n        (rst_n),
      .vs_i         (vs_i),
      .line_go_i    (line_go),
      .keep_i       (keep_line),
      .we_i         (we),
      .prior_i      (prior),
      .frame_mode_i (frame_mode),
      .wr_en_o      (wr_en_o),
      .wr_addr_o    (wr_addr_o),
      .frame_err_o  (frame_err_o)
   );

   // R11: a write always comes from a valid sample one cycle earlier
   a_r11_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |-> $past(vld_i));

   // R1: nothing is written before the first frame start
   a_r1_silent_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
      !prior |-> !wr_en_o);

   // R2: sample 0 of any line lies outside both centred windows
   if ((SMP_PER_LINE - WIN_525) / 2 > 0 && (SMP_PER_LINE - WIN_625) / 2 > 0) begin : g_head_chk
      a_r2_line_head_skipped: assert property (@(posedge clk) disable iff (!rst_n)
         $past(vs_i || hs_i) |-> !wr_en_o);
   end

endmodule

// File: tb/sim_vline_decimator.sv
module sim_vline_decimator;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        vs = 1'b0, hs = 1'b0, vld = 1'b0, sel = 1'b0;
   logic        wr_en, frame_err;
   logic [18:0] wr_addr;

   always #10 clk = ~clk;  // 50 MHz

   vline_decimator u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .vs_i        (vs),
      .hs_i        (hs),
      .vld_i       (vld),
      .std_sel_i   (sel),
      .wr_en_o     (wr_en),
      .wr_addr_o   (wr_addr),
      .frame_err_o (frame_err)
   );

   int n_chk = 0, n_bad = 0;
   int m_line = 0, m_smp = 0, m_addr = 0, m_kept = 0;
   bit m_mode = 0, m_seen = 0, m_lkeep = 0;

   function automatic bit keep_f(bit md, int ln);
      if (ln >= 768) return 0;
      if (!md) return !((ln % 8 == 2) || (ln % 8 == 5) || (ln % 8 == 7));
      return (ln % 3) != 2;
   endfunction

   function automatic bit win_f(bit md, int s);
      if (md) return (s >= 172) && (s <= 851);
      return (s >= 152) && (s <= 871);
   endfunction

   task automatic chk(string tag, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic cyc(string tag, bit v, bit h, bit d, bit m);
      bit exp_err, exp_we;
      int exp_a;
      vs = v; hs = h; vld = d; sel = m;
      exp_err = 0;
      if (v) begin
         exp_err = m_seen && (m_kept != (m_mode ? 512 : 480));
         m_line = 0; m_smp = 0; m_mode = m; m_addr = 0; m_kept = 0; m_seen = 1;
         m_lkeep = keep_f(m_mode, 0);
         if (m_lkeep) m_kept++;
      end else if (h) begin
         m_line++; m_smp = 0;
         m_lkeep = keep_f(m_mode, m_line);
         if (m_lkeep) m_kept++;
      end
      exp_we = d && m_seen && m_lkeep && win_f(m_mode, m_smp);
      exp_a  = m_addr;
      if (exp_we) m_addr++;
      if (d) m_smp++;
      @(posedge clk);
      #1;
      chk(tag, "wr_en", int'(wr_en), int'(exp_we));
      if (exp_we) chk("R9", "wr_addr", int'(wr_addr), exp_a);
      chk("R10", "frame_err", int'(frame_err), int'(exp_err));
   endtask

   // one frame: nl lines, a few full-length, the rest short
   task automatic frame(string tag, bit md, int nl, bit flip, int long_ln, bit both);
      for (int ln = 0; ln < nl; ln++) begin
         int n, got;
         bit first, pin;
         bit full;
         full = (ln < 9) || (ln == 400) || (ln >= 766);
         n = full ? 1024 : 2;
         if (ln == long_ln) n = 1030;
         got = 0;
         first = 1;
         while (got < n) begin
            bit d;
            d = ($urandom % 4) != 0;
            pin = (flip && ln >= 300) ? !md : md;
            if (first) begin
               cyc(tag, ln == 0, (ln != 0) || both, d, pin);
               first = 0;
            end else begin
               cyc(tag, 0, 0, d, pin);
            end
            if (d) got++;
         end
      end
   endtask

   initial begin
      void'($urandom(32'd1234));
      #1;
      repeat (3) @(posedge clk);
      #1;
      chk("R1", "wr_en at reset", int'(wr_en), 0);
      chk("R1", "frame_err at reset", int'(frame_err), 0);
      rst_n = 1'b1;
      // traffic before any frame start: nothing written
      for (int i = 0; i < 400; i++) cyc("R1", 0, (i % 50) == 0, 1, i[3]);
      frame("R3 R6 R11", 0, 768, 0, -1, 0);
      frame("R4 R7 R5", 1, 768, 1, -1, 0);
      frame("R3 R5", 0, 700, 1, -1, 0);
      // short frame closed with frame start, line start and valid together
      frame("R2 R4 R8", 1, 770, 0, 5, 1);
      frame("R3 R6", 0, 768, 0, -1, 0);
      cyc("R10", 1, 0, 0, 0);
      repeat (4) cyc("R11", 0, 0, 0, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (195000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule